// File: doc/BRIEF.md
# Serial ADC Frame Readout Controller

This block is the host-side master for a three-wire serial delta-sigma converter. On a start request it pulls chip select low and watches the converter's data line, which shows the end-of-conversion flag while the conversion runs. It generates no serial clock until that flag reads low. It then produces its own serial clock from the system clock. On 32 rising edges it captures a 32-bit frame, most significant bit first.

The frame holds the following fields:
- a four-bit status nibble in bits 31 to 28: end-of-conversion, dummy, sign and extended-range;
- a 24-bit conversion result in bits 27 to 4;
- four sub-LSB bits in bits 3 to 0.

The controller checks that the dummy bit is low and decodes the sign and range flags into a two-bit range class. It then presents the result with a one-cycle valid strobe.

A wait that never sees the flag go low is aborted after a fixed number of system clocks and reported as an error. The serial clock period is a runtime divider of the system clock. Chip select returns high after the frame, and the serial clock idles low whenever chip select is high.

Top module: `adc_frame_reader`

## Requirements
- R1: A synchronous active-high reset returns the block to idle: `cs_n` high, `sck` low, `result`, `sub_lsb`, `sign`, `ext_range` and `range_kind` zero, and `data_valid`, `frame_err` and `timeout_err` low.
- R2: A `start` pulse in idle drives `cs_n` low on the next clock. While `sdo` reads high after that, `sck` makes no rising edge. The first rising edge follows only after `sdo` has been seen low.
- R3: If `sdo` stays high for TIMEOUT_CYCLES system clocks after `cs_n` falls, `timeout_err` pulses for one clock exactly TIMEOUT_CYCLES clocks after `cs_n` fell. In that same clock `cs_n` returns high. No `sck` edge and no `data_valid` occur for that attempt.
- R4: One `sck` period lasts max(`sck_div`, 4) system clocks, with the high phase floor(period/2) clocks. The divider is captured when `start` is accepted, so later changes to `sck_div` do not alter the running frame. `sck` is low whenever `cs_n` is high.
- R5: Each frame makes exactly 32 rising `sck` edges. On each edge one `sdo` bit is taken, first the end-of-conversion bit (frame bit 31), down to frame bit 0.
- R6: At the end of the high phase after the 32nd rising edge, `sck` falls and `cs_n` rises in the same clock. For a good frame `data_valid` pulses for that one clock, with `result` = frame bits 27..4 and `sub_lsb` = frame bits 3..0.
- R7: With a good frame, `sign` = frame bit 29 and `ext_range` = frame bit 28. `range_kind` is 2'b00 for sign=1 and range=0 (normal positive), 2'b01 for sign=1 and range=1 (over-range), 2'b10 for sign=0 and range=1 (negative), and 2'b11 for sign=0 and range=0 (zero seen from below).
- R8: When frame bit 30 (dummy) reads high, `frame_err` pulses for one clock in place of `data_valid`. `result`, `sub_lsb`, `sign`, `ext_range` and `range_kind` keep their previous values.
- R9: A `start` pulse while a transfer is in progress is ignored. It neither adds `sck` edges to the running frame nor begins a new transfer after it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read one frame |
| sck_div | input | 8 | System clocks per serial clock period (values below 4 act as 4) |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select to the converter, active low |
| sck | output | 1 | Serial clock to the converter, idles low |
| result | output | 24 | Conversion result, frame bits 27..4 |
| sub_lsb | output | 4 | Sub-LSB bits, frame bits 3..0 |
| sign | output | 1 | Sign flag, frame bit 29 |
| ext_range | output | 1 | Extended-range flag, frame bit 28 |
| range_kind | output | 2 | Decoded range class (see R7) |
| data_valid | output | 1 | One-cycle strobe for a good frame |
| frame_err | output | 1 | One-cycle strobe for a frame whose dummy bit was high |
| timeout_err | output | 1 | One-cycle strobe for an aborted end-of-conversion wait |

## Verification
A phase counter that drifts shows up at once at the pins, as a serial clock period or high phase of the wrong length, measured edge to edge within the first period. A bit counter that is off by one shows up as a rising-edge count other than 32. Because the captured word is then shifted off, every decoded field reads wrong in the single cycle where the strobe fires. A control state stuck in polling or shifting shows up as chip select held low or serial clock edges while data is still busy. Both are visible within a few clocks of the event that caused the fault.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  localparam int FRAME_BITS = 32;
  localparam int RESULT_W   = 24;
  localparam int SUB_W      = 4;
  localparam int EOC_POS    = FRAME_BITS - 1;
  localparam int DUMMY_POS  = FRAME_BITS - 2;
  localparam int SIGN_POS   = FRAME_BITS - 3;
  localparam int RANGE_POS  = FRAME_BITS - 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_t;

  typedef enum logic [1:0] {
    RK_POS  = 2'b00,
    RK_OVER = 2'b01,
    RK_NEG  = 2'b10,
    RK_ZNEG = 2'b11
  } range_kind_t;

  // Sign and range flag pair mapped to a range class.
  function automatic logic [1:0] classify_range(input logic sgn, input logic exr);
    case ({sgn, exr})
      2'b11:   return RK_OVER;
      2'b10:   return RK_POS;
      2'b01:   return RK_NEG;
      default: return RK_ZNEG;
    endcase
  endfunction

  function automatic logic [RESULT_W-1:0] result_field(input logic [FRAME_BITS-1:0] f);
    return f[SUB_W +: RESULT_W];
  endfunction

  function automatic logic [SUB_W-1:0] sub_field(input logic [FRAME_BITS-1:0] f);
    return f[SUB_W-1:0];
  endfunction

endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise_evt,
  output logic             fall_evt
);

  localparam logic [DIV_W-1:0] MIN_D = DIV_W'(MIN_DIV);

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    return (d < MIN_D) ? MIN_D : d;
  endfunction

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] low_len;
  logic [DIV_W-1:0] ph;

  assign eff_div  = clamp_div(div);
  assign low_len  = eff_div - (eff_div >> 1);
  assign rise_evt = run && (ph == low_len - 1'b1);
  assign fall_evt = run && (ph == eff_div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph  <= '0;
      sck <= 1'b0;
    end else if (fall_evt) begin
      ph  <= '0;
      sck <= 1'b0;
    end else begin
      ph <= ph + 1'b1;
      if (rise_evt) sck <= 1'b1;
    end
  end

  // R4: a rising edge only starts from the low phase, a falling edge from the high one
  assert_rise_from_low_R4: assert property (@(posedge clk) disable iff (rst)
    rise_evt |-> !sck);
  assert_fall_from_high_R4: assert property (@(posedge clk) disable iff (rst)
    fall_evt |-> sck);

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  shift_en,
  input  logic                  din,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  full
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] bit_cnt;

  assign full = (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (shift_en) begin
      frame   <= {frame[FRAME_BITS-2:0], din};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R5: never more than one frame of shifts
  assert_no_overshift_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> !full);
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= LAST);

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_frame_pkg::*;
#(
  parameter int DIV_W          = 8,
  parameter int MIN_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [DIV_W-1:0]    sck_div,
  input  logic                sdo,
  output logic                cs_n,
  output logic                sck,
  output logic [RESULT_W-1:0] result,
  output logic [SUB_W-1:0]    sub_lsb,
  output logic                sign,
  output logic                ext_range,
  output logic [1:0]          range_kind,
  output logic                data_valid,
  output logic                frame_err,
  output logic                timeout_err
);

  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);

  rd_state_t              state;
  logic [TMO_W-1:0]       wait_cnt;
  logic [DIV_W-1:0]       div_q;
  logic [FRAME_BITS-1:0]  frame_q;
  logic                   frame_full;
  logic                   rise_evt;
  logic                   fall_evt;

  // Named internal events
  logic accept_start, eoc_seen, poll_expired, frame_done, dummy_bad;
  assign accept_start = (state == ST_IDLE) && start;
  assign eoc_seen     = (state == ST_POLL) && !sdo;
  assign poll_expired = (state == ST_POLL) && sdo && (wait_cnt == TMO_LAST);
  assign frame_done   = (state == ST_SHIFT) && fall_evt && frame_full;
  assign dummy_bad    = frame_q[DUMMY_POS];

  adc_sck_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_sck (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_SHIFT),
    .div      (div_q),
    .sck      (sck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  adc_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept_start),
    .shift_en (rise_evt),
    .din      (sdo),
    .frame    (frame_q),
    .full     (frame_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cs_n        <= 1'b1;
      wait_cnt    <= '0;
      div_q       <= '0;
      result      <= '0;
      sub_lsb     <= '0;
      sign        <= 1'b0;
      ext_range   <= 1'b0;
      range_kind  <= '0;
      data_valid  <= 1'b0;
      frame_err   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      data_valid  <= 1'b0;
      frame_err   <= 1'b0;
      timeout_err <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept_start) begin
          state    <= ST_POLL;
          cs_n     <= 1'b0;
          wait_cnt <= '0;
          div_q    <= sck_div;
        end
        ST_POLL: begin
          if (eoc_seen) begin
            state <= ST_SHIFT;
          end else if (poll_expired) begin
            state       <= ST_IDLE;
            cs_n        <= 1'b1;
            timeout_err <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_SHIFT: if (frame_done) begin
          state <= ST_IDLE;
          cs_n  <= 1'b1;
          if (dummy_bad) begin
            frame_err <= 1'b1;
          end else begin
            data_valid <= 1'b1;
            result     <= result_field(frame_q);
            sub_lsb    <= sub_field(frame_q);
            sign       <= frame_q[SIGN_POS];
            ext_range  <= frame_q[RANGE_POS];
            range_kind <= classify_range(frame_q[SIGN_POS], frame_q[RANGE_POS]);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: serial clock idles low with chip select high
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  // R2: no clocking while the busy flag is polled
  assert_no_sck_poll_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL) |-> (!sck && !rise_evt));
  // R5: the first captured bit is the end-of-conversion flag, which was low
  assert_eoc_low_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !frame_q[EOC_POS]);
  // R6: the strobe is a single clock and comes with chip select released
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);
  assert_valid_cs_R6: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> cs_n);
  // R6: chip select only rises together with an outcome strobe
  assert_cs_rise_outcome_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (data_valid || frame_err || timeout_err));
  // R8: a frame is either good or faulty, never both
  assert_err_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(data_valid && frame_err));
  // R3: an aborted wait releases chip select
  assert_timeout_release_R3: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (cs_n && !data_valid));

endmodule

// File: tb/adc_frame_reader_test.sv
module adc_frame_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  sck_div = 8'd4;
  logic        sdo;
  logic        cs_n, sck;
  logic [23:0] result;
  logic [3:0]  sub_lsb;
  logic        sign, ext_range;
  logic [1:0]  range_kind;
  logic        data_valid, frame_err, timeout_err;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // Converter model
  logic [31:0] adc_frame = '0;
  logic        adc_busy = 1'b1;
  int          idx = 31;
  // A pull-up holds the line high while chip select is released
  assign sdo = cs_n ? 1'b1 : (adc_busy ? 1'b1 : adc_frame[idx]);
  always @(negedge cs_n) idx = 31;
  always @(negedge sck) if (!cs_n && idx > 0) idx = idx - 1;

  adc_frame_reader #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst(rst), .start(start), .sck_div(sck_div), .sdo(sdo),
    .cs_n(cs_n), .sck(sck), .result(result), .sub_lsb(sub_lsb), .sign(sign),
    .ext_range(ext_range), .range_kind(range_kind), .data_valid(data_valid),
    .frame_err(frame_err), .timeout_err(timeout_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pin monitor, sampled away from the active edge
  int cyc = 0, rises = 0, last_rise = -1, per_min = 0, per_max = 0;
  int hi_min = 0, hi_max = 0, last_up = 0, valid_cnt = 0, ferr_cnt = 0;
  logic sck_q = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sck && !sck_q) begin
      rises++;
      if (last_rise >= 0) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      last_up = cyc;
    end
    if (!sck && sck_q) begin
      if (cyc - last_up < hi_min) hi_min = cyc - last_up;
      if (cyc - last_up > hi_max) hi_max = cyc - last_up;
    end
    if (data_valid) valid_cnt++;
    if (frame_err) ferr_cnt++;
    sck_q = sck;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; last_rise = -1; per_min = 1000000; per_max = 0;
    hi_min = 1000000; hi_max = 0; valid_cnt = 0; ferr_cnt = 0;
  endtask

  // Reads one frame; optionally pokes start and the divider mid-frame
  task automatic read_frame(input logic [31:0] f, input logic [7:0] div,
                            input int busy, input bit poke);
    int rb;
    bit poked = 0;
    adc_frame = f;
    adc_busy  = 1'b1;
    sck_div   = div;
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (busy) @(negedge clk);
    rb = rises;
    chk("R2 cs_n low while busy", {31'd0, cs_n}, 32'd0);
    chk("R2 no sck edge while busy", rb, 0);
    adc_busy = 1'b0;
    for (int i = 0; i < 20000 && !(data_valid || frame_err); i++) begin
      @(negedge clk);
      if (poke && !poked && rises == 10) begin
        start = 1'b1; sck_div = 8'd12; poked = 1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk("R6 cs_n high at strobe", {31'd0, cs_n}, 32'd1);
    chk("R6 sck low at strobe", {31'd0, sck}, 32'd0);
  endtask

  task automatic check_good(input logic [31:0] f, input int per, input string tag);
    logic [1:0] kind;
    if (f[29] && f[28]) kind = 2'b01;
    else if (f[29]) kind = 2'b00;
    else if (f[28]) kind = 2'b10;
    else kind = 2'b11;
    chk({"R5 edge count ", tag}, rises, 32);
    chk({"R4 period max ", tag}, per_max, per);
    chk({"R4 period min ", tag}, per_min, per);
    chk({"R4 high phase ", tag}, hi_max, per / 2);
    chk({"R4 high phase min ", tag}, hi_min, per / 2);
    chk({"R6 data_valid ", tag}, {31'd0, data_valid}, 32'd1);
    chk({"R6 result ", tag}, {8'd0, result}, {8'd0, f[27:4]});
    chk({"R6 sub_lsb ", tag}, {28'd0, sub_lsb}, {28'd0, f[3:0]});
    chk({"R7 sign ", tag}, {31'd0, sign}, {31'd0, f[29]});
    chk({"R7 ext_range ", tag}, {31'd0, ext_range}, {31'd0, f[28]});
    chk({"R7 range_kind ", tag}, {30'd0, range_kind}, {30'd0, kind});
    @(negedge clk);
    chk({"R6 single pulse ", tag}, valid_cnt, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 sck", {31'd0, sck}, 32'd0);
    chk("R1 outputs", {result, sub_lsb, sign, ext_range, range_kind},
        32'd0);
    chk("R1 strobes", {29'd0, data_valid, frame_err, timeout_err}, 32'd0);
  endtask

  task automatic t_positive();
    logic [31:0] f = {4'b0010, 24'hABCDEF, 4'h5};
    read_frame(f, 8'd4, 20, 0);
    check_good(f, 4, "positive");
  endtask

  task automatic t_over();
    logic [31:0] f = {4'b0011, 24'hFFFFF0, 4'hF};
    read_frame(f, 8'd7, 5, 0);
    check_good(f, 7, "over");
  endtask

  task automatic t_negative_min_div();
    logic [31:0] f = {4'b0001, 24'h123456, 4'h0};
    read_frame(f, 8'd1, 0, 0);
    check_good(f, 4, "negative div clamp");
  endtask

  task automatic t_zero();
    logic [31:0] f = {4'b0000, 24'h000000, 4'h9};
    read_frame(f, 8'd5, 3, 0);
    check_good(f, 5, "zero");
  endtask

  task automatic t_dummy();
    logic [31:0] f = {4'b0110, 24'h555555, 4'h3};
    read_frame(f, 8'd4, 2, 0);
    chk("R8 frame_err", {31'd0, frame_err}, 32'd1);
    chk("R8 no data_valid", {31'd0, data_valid}, 32'd0);
    chk("R8 result held", {8'd0, result}, 32'd0);
    chk("R8 sub_lsb held", {28'd0, sub_lsb}, 32'd9);
    chk("R8 flags held", {28'd0, sign, ext_range, range_kind}, 32'd3);
    @(negedge clk);
    chk("R8 single err pulse", ferr_cnt, 1);
  endtask

  task automatic t_timeout();
    int n = 0;
    adc_busy = 1'b1;
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!timeout_err && n < 5000) begin
      @(negedge clk); n++;
    end
    chk("R3 timeout delay", n, TMO);
    chk("R3 cs_n released", {31'd0, cs_n}, 32'd1);
    chk("R3 no sck edges", rises, 0);
    @(negedge clk);
    chk("R3 single pulse", {31'd0, timeout_err}, 32'd0);
    chk("R3 no data_valid", valid_cnt, 0);
  endtask

  task automatic t_ignore_start();
    logic [31:0] f = {4'b0010, 24'h0F0F0F, 4'hA};
    bit low_seen = 0;
    read_frame(f, 8'd6, 4, 1);
    check_good(f, 6, "R9 busy start and R4 div latch");
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!cs_n) low_seen = 1;
    end
    chk("R9 no queued transfer", {31'd0, low_seen}, 32'd0);
    chk("R9 edge count", rises, 32);
  endtask

  initial begin
    t_reset();
    t_positive();
    t_over();
    t_negative_min_div();
    t_zero();
    t_dummy();
    t_timeout();
    t_ignore_start();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule